// File: doc/BRIEF.md
# Dual-Mode Period Timer

This block is a timer that runs in one of two modes, picked by a control bit. In period mode the two counter bytes split apart. The low byte counts up, and the high byte holds a terminal value. When the low byte equals that value on a counting edge, the low byte restarts from zero. In wide mode the two bytes form a single word that counts through its full range and wraps to zero. Both the period restart and the wide wrap set one sticky flag. The flag also drives an interrupt output.

A CPU reaches the timer through a small byte-wide register port with four locations. Two of them hold the counter bytes. The third holds the control bits and the fourth holds the status flag. In wide mode the high byte goes through two separate buffers, so that a word always moves as a consistent pair. A low-byte read captures the live high byte for a later high-byte read. A high-byte write waits in a buffer until a low-byte write commits both bytes together. Counting happens only on cycles where the enable bit is set and the external count strobe is high.

Top module: `duo_timer`

## Requirements
- R1: After reset the counter bytes, the period byte, both buffers, the control bits and the flag are all zero, and `irq` is low.
- R2: The counter advances only on a clock edge where the enable bit and `cnt_en` are both high. On every other edge it holds its value.
- R3: In period mode (mode bit 0), a counting edge increments the low byte. If the low byte equals the high byte on that edge, the low byte becomes 0 instead. Counting never alters the high byte in this mode.
- R4: A period-mode restart sets the flag, which shows as status bit 0 and as `irq` high.
- R5: In wide mode (mode bit 1), a counting edge increments the 16-bit word {high, low} and carries from the low byte into the high byte. The step from 0xFFFF to 0x0000 sets the flag.
- R6: In wide mode, reading address 0 copies the live high byte into a read buffer at that edge. Reading address 1 returns that buffered copy, even if the counter has moved on since.
- R7: In wide mode, writing address 1 loads only a write buffer and leaves the counter unchanged. Writing address 0 then loads {write buffer, data} into the counter in one edge.
- R8: In period mode, address 1 reads and writes the period byte directly, with no buffering.
- R9: The flag is sticky. Writing a status byte with bit 0 set clears it, and writing bit 0 as 0 leaves it unchanged. If a restart or wrap happens on the same edge as a clear, the flag stays set.
- R10: Some writes change the counter: address 0 in either mode, and address 1 in period mode. Such a write replaces the counting step on its edge.
- R11: Register map: address 0 is the low byte, address 1 the high byte, address 2 the control byte (bit 0 enable, bit 1 mode) and address 3 the status byte (bit 0 flag). Control and status read back with their unused bits as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count strobe; a step needs this and the enable bit |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; needed for the low-byte capture side effect |
| reg_wdata | input | BYTE_W | Write data |
| reg_rdata | output | BYTE_W | Read data for reg_addr, combinational |
| irq | output | 1 | Sticky flag level |

## Verification
The bench builds the block with its default byte width of 8, so the word is 16 bits wide. At that width, loading 0xFFFE through the buffered write path brings the full-range wrap within two counting edges. A period of 3 makes each restart take only four strobes. The stale read-buffer case and the carry from low byte into high byte are driven by loading 0x12FF. Taking a single step then separates the captured high byte from the live one.

// File: rtl/duo_timer_pkg.sv
package duo_timer_pkg;

  localparam int ADDR_W        = 2;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int STAT_FLAG_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/duo_timer_regif.sv
module duo_timer_regif
  import duo_timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [BYTE_W-1:0]    reg_wdata,
  input  logic [BYTE_W-1:0]    cnt_lo,
  input  logic [BYTE_W-1:0]    cnt_hi,
  input  logic                 flag,
  output logic [BYTE_W-1:0]    reg_rdata,
  output logic                 run_en,
  output logic                 mode_wide,
  output logic                 ld_lo,
  output logic                 ld_hi,
  output logic                 ld_word,
  output logic [BYTE_W-1:0]    ld_lo_val,
  output logic [BYTE_W-1:0]    ld_hi_val,
  output logic                 flag_clr
);

  logic              en_q, mode_q;
  logic [BYTE_W-1:0] wbuf_q, rbuf_q;
  logic              wr_lo, wr_hi, wr_ctrl, wr_stat, rd_lo;

  assign wr_lo   = reg_wr && (reg_addr == REG_LO);
  assign wr_hi   = reg_wr && (reg_addr == REG_HI);
  assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
  assign wr_stat = reg_wr && (reg_addr == REG_STAT);
  assign rd_lo   = reg_rd && (reg_addr == REG_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      wbuf_q <= '0;
      rbuf_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= reg_wdata[CTRL_EN_BIT];
        mode_q <= reg_wdata[CTRL_MODE_BIT];
      end
      if (wr_hi && mode_q) wbuf_q <= reg_wdata;
      if (rd_lo)           rbuf_q <= cnt_hi;
    end
  end

  assign run_en    = en_q;
  assign mode_wide = mode_q;
  assign ld_lo     = wr_lo && !mode_q;
  assign ld_word   = wr_lo && mode_q;
  assign ld_hi     = wr_hi && !mode_q;
  assign ld_lo_val = reg_wdata;
  assign ld_hi_val = mode_q ? wbuf_q : reg_wdata;
  assign flag_clr  = wr_stat && reg_wdata[STAT_FLAG_BIT];

  always_comb begin
    reg_rdata = '0;
    case (reg_sel_e'(reg_addr))
      REG_LO:   reg_rdata = cnt_lo;
      REG_HI:   reg_rdata = mode_q ? rbuf_q : cnt_hi;
      REG_CTRL: begin
        reg_rdata[CTRL_EN_BIT]   = en_q;
        reg_rdata[CTRL_MODE_BIT] = mode_q;
      end
      REG_STAT: reg_rdata[STAT_FLAG_BIT] = flag;
      default:  reg_rdata = '0;
    endcase
  end

  AST_RBUF_ONLY_ON_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(rbuf_q)); // R6

  AST_WBUF_ONLY_ON_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(wbuf_q)); // R7

endmodule

// File: rtl/duo_timer_count.sv
module duo_timer_count #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode_wide,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              ld_word,
  input  logic [BYTE_W-1:0] ld_lo_val,
  input  logic [BYTE_W-1:0] ld_hi_val,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              wrap_evt
);

  localparam int WORD_W = 2 * BYTE_W;

  function automatic logic [WORD_W-1:0] wide_step(input logic [WORD_W-1:0] w);
    return w + WORD_W'(1);
  endfunction

  function automatic logic period_hit(input logic [BYTE_W-1:0] lo,
                                      input logic [BYTE_W-1:0] hi);
    return lo == hi;
  endfunction

  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [WORD_W-1:0] word;
  logic              any_ld, step, hit8, top16;

  assign word     = {hi_q, lo_q};
  assign any_ld   = ld_lo || ld_hi || ld_word;
  assign step     = tick && !any_ld;
  assign hit8     = period_hit(lo_q, hi_q);
  assign top16    = &word;
  assign wrap_evt = step && (mode_wide ? top16 : hit8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (ld_word) begin
      {hi_q, lo_q} <= {ld_hi_val, ld_lo_val};
    end else if (ld_lo) begin
      lo_q <= ld_lo_val;
    end else if (ld_hi) begin
      hi_q <= ld_hi_val;
    end else if (step) begin
      if (mode_wide) {hi_q, lo_q} <= wide_step(word);
      else           lo_q <= hit8 ? '0 : lo_q + BYTE_W'(1);
    end
  end

  assign cnt_lo = lo_q;
  assign cnt_hi = hi_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !any_ld) |=> ($stable(lo_q) && $stable(hi_q))); // R2

  AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mode_wide && (lo_q == hi_q)) |=> (lo_q == '0)); // R3

  AST_PERIOD_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_wide && !ld_hi) |=> $stable(hi_q)); // R3

  AST_WIDE_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_wide && (&{hi_q, lo_q})) |=> ({hi_q, lo_q} == '0)); // R5

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> (lo_q == $past(ld_lo_val))); // R10

endmodule

// File: rtl/duo_timer_flag.sv
module duo_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q); // R9

  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q); // R4

endmodule

// File: rtl/duo_timer.sv
module duo_timer
  import duo_timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq
);

  logic              run_en, mode_wide, tick;
  logic              ld_lo, ld_hi, ld_word, flag_clr, wrap_evt, flag;
  logic [BYTE_W-1:0] ld_lo_val, ld_hi_val, cnt_lo, cnt_hi;

  assign tick = run_en && cnt_en;

  duo_timer_regif #(.BYTE_W(BYTE_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .flag      (flag),
    .reg_rdata (reg_rdata),
    .run_en    (run_en),
    .mode_wide (mode_wide),
    .ld_lo     (ld_lo),
    .ld_hi     (ld_hi),
    .ld_word   (ld_word),
    .ld_lo_val (ld_lo_val),
    .ld_hi_val (ld_hi_val),
    .flag_clr  (flag_clr)
  );

  duo_timer_count #(.BYTE_W(BYTE_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode_wide (mode_wide),
    .ld_lo     (ld_lo),
    .ld_hi     (ld_hi),
    .ld_word   (ld_word),
    .ld_lo_val (ld_lo_val),
    .ld_hi_val (ld_hi_val),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .wrap_evt  (wrap_evt)
  );

  duo_timer_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (wrap_evt),
    .clr_req (flag_clr),
    .flag_q  (flag)
  );

  assign irq = flag;

  AST_WIDE_HI_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wide && reg_wr && (reg_addr == REG_HI) && !tick)
      |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R7

  AST_NO_STEP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !wrap_evt); // R2

endmodule

// File: tb/tb_duo_timer.sv
module tb_duo_timer;

  localparam int BW = 8;
  localparam logic [7:0] OP_WR = 8'h01, OP_RD = 8'h02, OP_TK = 8'h03;
  localparam int NV = 43;
  // fields: {req, op, addr, data, expected}
  localparam logic [39:0] VEC [NV] = '{
    40'h0B_01_02_01_00, // R11 enable, period mode
    40'h0B_02_02_00_01, // R11 control readback
    40'h08_01_01_03_00, // R8 period byte = 3
    40'h08_02_01_00_03, // R8 direct readback
    40'h03_03_00_02_00, // R3 two steps
    40'h03_02_00_00_02, // R3 low = 2
    40'h04_03_00_01_00, // R4 step to 3
    40'h04_02_03_00_00, // R4 equal but not yet restarted: flag 0
    40'h03_03_00_01_00, // R3 restart step
    40'h03_02_00_00_00, // R3 low back to 0
    40'h03_02_01_00_03, // R3 period byte untouched
    40'h04_02_03_00_01, // R4 flag set
    40'h09_01_03_00_00, // R9 write 0: no effect
    40'h09_02_03_00_01, // R9
    40'h09_01_03_01_00, // R9 write 1 clears
    40'h09_02_03_00_00, // R9
    40'h02_03_00_01_00, // R2 low = 1
    40'h02_01_02_00_00, // R2 disable
    40'h02_03_00_04_00, // R2 strobes while disabled
    40'h02_02_00_00_01, // R2 low held at 1
    40'h0B_01_02_03_00, // R11 enable, wide mode
    40'h0B_02_02_00_03, // R11
    40'h07_01_01_FF_00, // R7 high write to buffer only
    40'h07_02_00_00_01, // R7 low unchanged (captures high 03)
    40'h07_02_01_00_03, // R7 high unchanged
    40'h07_01_00_FE_00, // R7 commit -> FFFE
    40'h07_02_00_00_FE, // R7
    40'h07_02_01_00_FF, // R7
    40'h05_03_00_01_00, // R5 -> FFFF
    40'h05_02_03_00_00, // R5 no flag yet
    40'h05_02_00_00_FF, // R5
    40'h05_03_00_01_00, // R5 -> 0000
    40'h05_02_03_00_01, // R5 wrap sets flag
    40'h05_02_00_00_00, // R5
    40'h05_02_01_00_00, // R5
    40'h09_01_03_01_00, // R9 clear
    40'h06_01_01_12_00, // R6 buffer 12
    40'h06_01_00_FF_00, // R6 commit 12FF
    40'h06_02_00_00_FF, // R6 capture 12
    40'h06_03_00_01_00, // R6 -> 1300
    40'h06_02_01_00_12, // R6 stale buffered copy
    40'h05_02_00_00_00, // R5 carry, capture 13
    40'h05_02_01_00_13  // R5 carry into high byte
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [BW-1:0] reg_wdata = '0;
  logic [BW-1:0] reg_rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  duo_timer #(.BYTE_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d cycles expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle_pins();
    reg_wr = 1'b0; reg_rd = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); idle_pins();
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
  endtask

  task automatic do_wr_tick(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); idle_pins();
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; cnt_en = 1'b1;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idle_pins(); cnt_en = 1'b1;
    end
  endtask

  task automatic do_rd(input logic [1:0] a, input logic [7:0] exp, input int req);
    @(negedge clk); idle_pins();
    reg_addr = a; reg_rd = 1'b1;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      failures++;
      $display("FAIL R%0d addr=%0d actual=%02h expected=%02h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input int req);
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL R%0d irq actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state on every register and the irq pin
    do_rd(2'd0, 8'h00, 1);
    do_rd(2'd1, 8'h00, 1);
    do_rd(2'd2, 8'h00, 1);
    do_rd(2'd3, 8'h00, 1);
    chk_irq(1'b0, 1);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] rq, op, ad, dt, ex;
      {rq, op, ad, dt, ex} = VEC[v];
      case (op)
        OP_WR:   do_wr(ad[1:0], dt);
        OP_RD:   do_rd(ad[1:0], ex, int'(rq));
        OP_TK:   do_tick(int'(dt));
        default: ;
      endcase
    end

    // R10: low-byte write in the same cycle as a step wins, period mode
    do_wr(2'd2, 8'h01);
    do_wr(2'd1, 8'h50);
    do_wr_tick(2'd0, 8'h40);
    do_rd(2'd0, 8'h40, 10);

    // R9: restart coinciding with a clear leaves the flag set
    do_wr(2'd1, 8'h05);
    do_wr(2'd0, 8'h05);
    do_wr_tick(2'd3, 8'h01);
    do_rd(2'd3, 8'h01, 9);
    chk_irq(1'b1, 4); // R4 irq follows the flag
    do_rd(2'd0, 8'h00, 3);

    // R9 then a plain clear drops irq
    do_wr(2'd3, 8'h01);
    do_rd(2'd3, 8'h00, 9);
    chk_irq(1'b0, 9);

    @(negedge clk); idle_pins();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule